// File: doc/BRIEF.md
# Slave Port Bus Arbiter

This block decides which of up to sixteen bus masters may use one shared slave port. Each master presents a request line, together with per-beat, burst-start and burst-end strobes. The arbiter returns a registered one-hot grant, the index of the owner, and an owner-valid flag. The grant stays with the owner for the length of its burst. A new decision is taken only when the owner goes idle, ends a burst, hits its own undefined-length break point, or runs out its slot-cycle budget while another master is waiting.

All configuration arrives on plain inputs and may change at run time. One input picks either round-robin or fixed-priority selection, and fixed priority uses a 2-bit level per master. An 8-bit budget caps the cycles of one tenure. A per-master 3-bit code forces a break after 1, 4, 8 or 16 beats. An idle policy leaves the port ungranted, parks it on the previous owner, or parks it on a fixed master index. A master that is already parked and raises its request keeps the port with no lost cycle.

Top module: `slave_port_arbiter`

## Requirements
- R1: While rst_n is low, grant_o is all zero and owner_vld_o is low. The last-owner record is cleared, so the first round-robin search after reset starts at master 0.
- R2: grant_o has at most one bit set. owner_vld_o is high exactly when grant_o is non-zero, and owner_o then holds the index of the set bit (0 when none).
- R3: With arb_mode_i at any value other than 1, the search among requesters starts at the master after the last owner and wraps around modulo NUM_M.
- R4: With arb_mode_i equal to 1, the requester with the highest 2-bit level prio_i[2i+1:2i] wins, and a tie goes to the lower index.
- R5: With slot_limit_i equal to L (1 to 255), an owner that keeps requesting while another master requests holds the grant for exactly L cycles. A different requester is then granted at the next edge.
- R6: When the slot budget runs out and no other master requests, the owner keeps the grant and its cycle count starts over.
- R7: A slot_limit_i of 0 places no cycle limit on a tenure.
- R8: The code ulbt_i[3i+2:3i] of the owner forces a re-arbitration among all requesters, including the owner. Code 1 breaks after 1 beat, 2 after 4, 3 after 8 and 4 after 16. The beat count restarts at a beat flagged as burst start, and that beat counts as the first.
- R9: Break codes 0, 5, 6 and 7 never force a break.
- R10: The grant changes only in the edge after a cycle in which one of these holds: the owner's request is low, the owner makes a beat with burst end, the owner reaches an R8 break, or an R5 expiry occurs.
- R11: With park_mode_i at 0 or 3, a re-arbitration that finds no requester leaves grant_o all zero.
- R12: With park_mode_i at 1, a re-arbitration that finds no requester grants the last master that won arbitration. A parked master that raises its request keeps the grant without a gap.
- R13: With park_mode_i at 2, a re-arbitration that finds no requester grants master park_idx_i, and that master keeps the grant when it starts requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_M | Request, one bit per master |
| beat_i | input | NUM_M | Data beat made this cycle, per master |
| start_i | input | NUM_M | Beat is the first of a burst, per master |
| end_i | input | NUM_M | Beat is the last of a burst, per master |
| prio_i | input | 2*NUM_M | 2-bit priority level per master |
| ulbt_i | input | 3*NUM_M | 3-bit forced-break code per master |
| arb_mode_i | input | 2 | 1 = fixed priority, other values = round-robin |
| slot_limit_i | input | SLOT_W | Cycle budget per tenure, 0 = unlimited |
| park_mode_i | input | 2 | Idle policy: 0/3 none, 1 last owner, 2 fixed index |
| park_idx_i | input | IW | Master to park on in fixed mode |
| grant_o | output | NUM_M | One-hot grant |
| owner_o | output | IW | Index of the granted master |
| owner_vld_o | output | 1 | A master holds the grant |

## Verification
Directed sequences separate the two selection policies. A rotation over three masters that end every beat shows the round-robin pointer. Unequal levels with a tie show both the priority and the tie rule. Back-to-back streams without burst ends show the cycle budget against the case with no budget and the case with a single requester. Unbroken beat streams tell the break codes apart. Idle gaps under each parking policy show where the grant rests, and a reset pulse shows that the pointer is cleared. Constrained-random phases then mix sticky requests, random beats and burst edges, and random configuration, against a cycle model of the rules.

// File: rtl/slvarb_pkg.sv
package slvarb_pkg;

  typedef enum logic [1:0] {
    PARK_NONE  = 2'd0,
    PARK_LAST  = 2'd1,
    PARK_FIXED = 2'd2,
    PARK_RSVD  = 2'd3
  } park_e;

  localparam logic [1:0] ARB_FIXED_PRIO = 2'd1;
  localparam int         BEAT_W         = 5;

  // Beats allowed before a forced break; zero means never.
  function automatic logic [BEAT_W-1:0] brk_len(input logic [2:0] code);
    case (code)
      3'd1:    brk_len = BEAT_W'(1);
      3'd2:    brk_len = BEAT_W'(4);
      3'd3:    brk_len = BEAT_W'(8);
      3'd4:    brk_len = BEAT_W'(16);
      default: brk_len = '0;
    endcase
  endfunction

endpackage

// File: rtl/slvarb_rr_pick.sv
module slvarb_rr_pick #(
  parameter int NUM_M = 16,
  parameter int IW    = 4
) (
  input  logic [NUM_M-1:0] cand_i,
  input  logic [IW-1:0]    base_i,
  output logic             found_o,
  output logic [IW-1:0]    pick_o
);

  // First candidate strictly after base, wrapping around.
  always_comb begin
    int idx;
    found_o = 1'b0;
    pick_o  = '0;
    idx     = 0;
    for (int k = 0; k < NUM_M; k++) begin
      idx = (int'(base_i) + 1 + k) % NUM_M;
      if (!found_o && cand_i[IW'(idx)]) begin
        found_o = 1'b1;
        pick_o  = IW'(idx);
      end
    end
  end

  always_comb begin
    p_rr_found_r3: assert (found_o == (|cand_i));
    p_rr_valid_r3: assert (!found_o || cand_i[pick_o]);
  end

endmodule

// File: rtl/slvarb_fp_pick.sv
module slvarb_fp_pick #(
  parameter int NUM_M = 16,
  parameter int IW    = 4
) (
  input  logic [NUM_M-1:0]      cand_i,
  input  logic [NUM_M-1:0][1:0] prio_i,
  output logic                  found_o,
  output logic [IW-1:0]         pick_o
);

  logic [1:0] best;

  // Scan from the top index down; ">=" lets a lower index win a tie.
  always_comb begin
    found_o = 1'b0;
    pick_o  = '0;
    best    = '0;
    for (int i = NUM_M - 1; i >= 0; i--) begin
      if (cand_i[IW'(i)] && (!found_o || prio_i[IW'(i)] >= best)) begin
        found_o = 1'b1;
        pick_o  = IW'(i);
        best    = prio_i[IW'(i)];
      end
    end
  end

  always_comb begin
    p_fp_valid_r4: assert (!found_o || cand_i[pick_o]);
    for (int i = 0; i < NUM_M; i++) begin
      p_fp_best_r4: assert (!(found_o && cand_i[IW'(i)] &&
                              (prio_i[IW'(i)] > prio_i[pick_o])));
    end
  end

endmodule

// File: rtl/slvarb_burst_ctl.sv
module slvarb_burst_ctl #(
  parameter int SLOT_W = 8,
  parameter int BEAT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              held_i,
  input  logic              beat_i,
  input  logic              start_i,
  input  logic              end_i,
  input  logic [BEAT_W-1:0] len_i,
  input  logic [SLOT_W-1:0] limit_i,
  input  logic              others_i,
  output logic              rearb_o,
  output logic              take_o
);

  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [BEAT_W-1:0] beat_q, beat_d, beat_inc;
  logic              held_beat, nat_end, brk, expire, cnt_en;

  always_comb begin
    beat_inc  = start_i ? BEAT_W'(1) : beat_q + BEAT_W'(1);
    held_beat = held_i & beat_i;
    nat_end   = held_beat & end_i;
    brk       = held_beat & (len_i != '0) & (beat_inc == len_i);
    expire    = held_i & (limit_i != '0) & (slot_q >= limit_i - SLOT_W'(1));
    take_o    = expire & others_i;
    rearb_o   = ~held_i | nat_end | brk | take_o;
  end

  always_comb begin
    cnt_en = held_i | (slot_q != '0) | (beat_q != '0);
    if (rearb_o) begin
      slot_d = '0;
      beat_d = '0;
    end else begin
      slot_d = expire ? '0 : slot_q + SLOT_W'(1);
      beat_d = held_beat ? beat_inc : beat_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      beat_q <= '0;
    end else if (cnt_en) begin
      slot_q <= slot_d;
      beat_q <= beat_d;
    end
  end

  p_single_brk_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (held_i && beat_i && len_i == BEAT_W'(1)) |-> rearb_o);

  p_limit_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (held_i && limit_i == SLOT_W'(1) && others_i) |-> take_o);

  p_no_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_i == '0) |-> !take_o);

endmodule

// File: rtl/slave_port_arbiter.sv
module slave_port_arbiter
  import slvarb_pkg::*;
#(
  parameter  int NUM_M  = 16,
  parameter  int SLOT_W = 8,
  localparam int IW     = (NUM_M > 1) ? $clog2(NUM_M) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_M-1:0]     req_i,
  input  logic [NUM_M-1:0]     beat_i,
  input  logic [NUM_M-1:0]     start_i,
  input  logic [NUM_M-1:0]     end_i,
  input  logic [2*NUM_M-1:0]   prio_i,
  input  logic [3*NUM_M-1:0]   ulbt_i,
  input  logic [1:0]           arb_mode_i,
  input  logic [SLOT_W-1:0]    slot_limit_i,
  input  logic [1:0]           park_mode_i,
  input  logic [IW-1:0]        park_idx_i,
  output logic [NUM_M-1:0]     grant_o,
  output logic [IW-1:0]        owner_o,
  output logic                 owner_vld_o
);

  logic [NUM_M-1:0][1:0] prio_a;
  logic [NUM_M-1:0][2:0] ulbt_a;

  for (genvar g = 0; g < NUM_M; g++) begin : g_unpack
    assign prio_a[g] = prio_i[2*g +: 2];
    assign ulbt_a[g] = ulbt_i[3*g +: 3];
  end

  logic [IW-1:0]     own_q, own_d, last_q, last_d, rr_base;
  logic              vld_q, vld_d, lvld_q, lvld_d;
  logic [NUM_M-1:0]  own_oh, cand;
  logic              held, o_beat, o_start, o_end, others;
  logic [BEAT_W-1:0] o_len;
  logic              rearb, take;
  logic              rr_found, fp_found;
  logic [IW-1:0]     rr_pick, fp_pick;

  always_comb begin
    own_oh = '0;
    if (vld_q) own_oh[own_q] = 1'b1;
    held    = |(own_oh & req_i);
    o_beat  = |(own_oh & beat_i);
    o_start = |(own_oh & start_i);
    o_end   = |(own_oh & end_i);
    o_len   = brk_len(ulbt_a[own_q]);
    others  = |(req_i & ~own_oh);
  end

  slvarb_burst_ctl #(.SLOT_W(SLOT_W), .BEAT_W(BEAT_W)) u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .held_i   (held),
    .beat_i   (o_beat),
    .start_i  (o_start),
    .end_i    (o_end),
    .len_i    (o_len),
    .limit_i  (slot_limit_i),
    .others_i (others),
    .rearb_o  (rearb),
    .take_o   (take)
  );

  // A budget expiry hands over to someone else; other points include the owner.
  assign cand    = take ? (req_i & ~own_oh) : req_i;
  assign rr_base = lvld_q ? last_q : IW'(NUM_M - 1);

  slvarb_rr_pick #(.NUM_M(NUM_M), .IW(IW)) u_rr (
    .cand_i  (cand),
    .base_i  (rr_base),
    .found_o (rr_found),
    .pick_o  (rr_pick)
  );

  slvarb_fp_pick #(.NUM_M(NUM_M), .IW(IW)) u_fp (
    .cand_i  (cand),
    .prio_i  (prio_a),
    .found_o (fp_found),
    .pick_o  (fp_pick)
  );

  always_comb begin
    own_d  = own_q;
    vld_d  = vld_q;
    last_d = last_q;
    lvld_d = lvld_q;
    if (|cand) begin
      vld_d  = 1'b1;
      own_d  = (arb_mode_i == ARB_FIXED_PRIO) ? fp_pick : rr_pick;
      last_d = own_d;
      lvld_d = 1'b1;
    end else begin
      case (park_e'(park_mode_i))
        PARK_LAST: begin
          vld_d = lvld_q;
          own_d = last_q;
        end
        PARK_FIXED: begin
          if (int'(park_idx_i) < NUM_M) begin
            vld_d = 1'b1;
            own_d = park_idx_i;
          end else begin
            vld_d = 1'b0;
          end
        end
        default: vld_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q  <= '0;
      vld_q  <= 1'b0;
      last_q <= '0;
      lvld_q <= 1'b0;
    end else if (rearb) begin
      own_q  <= own_d;
      vld_q  <= vld_d;
      last_q <= last_d;
      lvld_q <= lvld_d;
    end
  end

  assign grant_o     = own_oh;
  assign owner_o     = vld_q ? own_q : '0;
  assign owner_vld_o = vld_q;

  p_grant_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rearb |=> $stable(grant_o));

  p_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (grant_o != $past(grant_o)) && owner_vld_o);

  p_park_none_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == '0 && (park_mode_i == 2'd0 || park_mode_i == 2'd3)) |=> (grant_o == '0));

  p_park_fixed_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == '0 && park_mode_i == 2'd2 && int'(park_idx_i) < NUM_M)
      |=> (owner_vld_o && owner_o == $past(park_idx_i)));

endmodule

// File: tb/slave_port_arbiter_tb.sv
module slave_port_arbiter_tb_top;

  localparam int N  = 16;
  localparam int IW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_n;
  logic [N-1:0]   req, beat, bst, bend;
  logic [2*N-1:0] prio;
  logic [3*N-1:0] ulbt;
  logic [1:0]     arb, park;
  logic [7:0]     slot;
  logic [IW-1:0]  pidx;
  logic [N-1:0]   grant;
  logic [IW-1:0]  owner;
  logic           owner_vld;

  slave_port_arbiter #(.NUM_M(N), .SLOT_W(8)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req),
    .beat_i       (beat),
    .start_i      (bst),
    .end_i        (bend),
    .prio_i       (prio),
    .ulbt_i       (ulbt),
    .arb_mode_i   (arb),
    .slot_limit_i (slot),
    .park_mode_i  (park),
    .park_idx_i   (pidx),
    .grant_o      (grant),
    .owner_o      (owner),
    .owner_vld_o  (owner_vld)
  );

  int n_chk = 0;
  int n_bad = 0;

  bit m_vld, m_lvld;
  int m_own, m_last, m_slot, m_beat;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int len_of(input logic [2:0] c);
    case (c)
      3'd1: return 1;
      3'd2: return 4;
      3'd3: return 8;
      3'd4: return 16;
      default: return 0;
    endcase
  endfunction

  task automatic model_step();
    bit held, hb, nat, brk, ex, oth, take, re, any;
    int bn, len, w, base;
    logic [N-1:0] cand;
    held = m_vld && req[m_own];
    hb   = held && beat[m_own];
    bn   = bst[m_own] ? 1 : (m_beat + 1) % 32;
    len  = len_of(ulbt[3*m_own +: 3]);
    nat  = hb && bend[m_own];
    brk  = hb && len != 0 && bn == len;
    ex   = held && slot != 0 && m_slot >= int'(slot) - 1;
    oth  = 1'b0;
    for (int i = 0; i < N; i++) if (req[i] && !(m_vld && i == m_own)) oth = 1'b1;
    take = ex && oth;
    re   = !held || nat || brk || take;
    if (!re) begin
      m_slot = ex ? 0 : (m_slot + 1) % 256;
      if (hb) m_beat = bn;
    end else begin
      m_slot = 0;
      m_beat = 0;
      any = 1'b0;
      for (int i = 0; i < N; i++) begin
        cand[i] = req[i] && !(take && i == m_own);
        if (cand[i]) any = 1'b1;
      end
      if (any) begin
        w = -1;
        if (arb == 2'd1) begin
          for (int i = 0; i < N; i++)
            if (cand[i] && (w < 0 || prio[2*i +: 2] > prio[2*w +: 2])) w = i;
        end else begin
          base = m_lvld ? m_last : N - 1;
          for (int k = 1; k <= N; k++)
            if (w < 0 && cand[(base + k) % N]) w = (base + k) % N;
        end
        m_own = w; m_vld = 1'b1; m_last = w; m_lvld = 1'b1;
      end else begin
        case (park)
          2'd1: begin m_vld = m_lvld; m_own = m_last; end
          2'd2: begin m_vld = 1'b1; m_own = int'(pidx); end
          default: m_vld = 1'b0;
        endcase
      end
    end
  endtask

  task automatic tick();
    logic [N-1:0] eg;
    model_step();
    @(posedge clk);
    #1;
    eg = m_vld ? (N'(1) << m_own) : '0;
    chk(grant === eg, "R10 grant vs cycle model", 32'(grant), 32'(eg));
    chk(($countones(grant) <= 1) && (owner_vld == (grant != '0)) &&
        (owner == (m_vld ? IW'(m_own) : IW'(0))), "R2 one-hot/owner", 32'(owner), 32'(m_own));
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_vld = 0; m_lvld = 0; m_own = 0; m_last = 0; m_slot = 0; m_beat = 0;
    #1;
    chk(grant == '0 && !owner_vld, "R1 reset grant", 32'(grant), 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic quiet();
    req = '0; beat = '0; bst = '0; bend = '0; prio = '0; ulbt = '0;
    arb = 2'd0; slot = 8'd0; park = 2'd0; pidx = '0;
  endtask

  initial begin
    #(8 * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int a;
    logic [N-1:0] mask;
    void'($urandom(32'h1B2C3D4E));
    quiet();
    rst_n = 1'b1;
    do_reset();

    // R3: rotation over three masters that end every beat
    req = 16'h0007; beat = 16'h0007; bend = 16'h0007;
    tick(); chk(owner == 0, "R3 rr first", 32'(owner), 0);
    tick(); chk(owner == 1, "R3 rr next", 32'(owner), 1);
    tick(); chk(owner == 2, "R3 rr next", 32'(owner), 2);
    tick(); chk(owner == 0, "R3 rr wrap", 32'(owner), 0);

    // R4: levels m1=2, m2=1, m3=2
    arb = 2'd1; prio = '0; prio[3:2] = 2'd2; prio[5:4] = 2'd1; prio[7:6] = 2'd2;
    req = 16'h000E; beat = 16'h000E; bend = 16'h000E;
    tick(); chk(owner == 1, "R4 tie lower index", 32'(owner), 1);
    tick(); chk(owner == 1, "R4 highest wins again", 32'(owner), 1);
    req = 16'h000C; tick(); chk(owner == 3, "R4 highest level", 32'(owner), 3);
    req = 16'h0004; tick(); chk(owner == 2, "R4 sole requester", 32'(owner), 2);
    quiet(); ticks(2);

    // R5: budget of 3 cycles with two masters contending
    slot = 8'd3; req = 16'h0003;
    tick(); a = int'(owner);
    chk(owner_vld && a < 2, "R5 first grant", 32'(owner), 0);
    ticks(2); chk(int'(owner) == a, "R5 held within budget", 32'(owner), 32'(a));
    tick(); chk(int'(owner) == 1 - a, "R5 handover after L cycles", 32'(owner), 32'(1 - a));
    a = 1 - a;
    // R6: budget expires with nobody else waiting
    req = N'(1) << a;
    ticks(8); chk(int'(owner) == a && owner_vld, "R6 owner kept", 32'(owner), 32'(a));
    // R7: no budget
    slot = 8'd0; req = 16'h0003;
    ticks(20); chk(int'(owner) == a, "R7 unlimited tenure", 32'(owner), 32'(a));

    // R8: four-beat break on both masters
    ulbt[2:0] = 3'd2; ulbt[5:3] = 3'd2; beat = 16'h0003;
    ticks(3); chk(int'(owner) == a, "R8 before 4th beat", 32'(owner), 32'(a));
    tick(); chk(int'(owner) == 1 - a, "R8 break after 4 beats", 32'(owner), 32'(1 - a));
    a = 1 - a;
    ulbt[2:0] = 3'd1; ulbt[5:3] = 3'd1;
    tick(); chk(int'(owner) == 1 - a, "R8 single access break", 32'(owner), 32'(1 - a));
    tick(); chk(int'(owner) == a, "R8 single access break", 32'(owner), 32'(a));
    // R9: reserved code never breaks
    ulbt[2:0] = 3'd6; ulbt[5:3] = 3'd6;
    ticks(25); chk(int'(owner) == a, "R9 no forced break", 32'(owner), 32'(a));
    quiet(); ticks(2);

    // R11: no parking for codes 0 and 3
    tick(); chk(grant == '0, "R11 park none", 32'(grant), 0);
    park = 2'd3; tick(); chk(grant == '0, "R11 park code 3", 32'(grant), 0);
    // R12: park on last owner
    park = 2'd1; req = 16'h0020; tick();
    req = '0; ticks(2); chk(owner_vld && owner == 5, "R12 park last", 32'(owner), 5);
    req = 16'h0020; tick(); chk(owner_vld && owner == 5, "R12 no gap", 32'(owner), 5);
    // R13: park on a fixed index
    park = 2'd2; pidx = 4'd9; req = '0;
    tick(); chk(owner_vld && owner == 9, "R13 park fixed", 32'(owner), 9);
    req = 16'h0200; tick(); chk(owner == 9, "R13 parked master keeps", 32'(owner), 9);
    req = 16'h0010; tick(); chk(owner == 4, "R13 leaves park", 32'(owner), 4);

    // R1: reset clears the pointer (without clearing, 5 would win)
    quiet(); do_reset();
    req = 16'hFFFF; tick(); chk(owner_vld && owner == 0, "R1 pointer cleared", 32'(owner), 0);

    // Constrained-random phases
    for (int ph = 0; ph < 12; ph++) begin
      arb  = 2'(ph % 3);
      park = 2'(ph % 4);
      pidx = IW'($urandom_range(0, N - 1));
      slot = (ph % 4 == 0) ? 8'd0 : 8'($urandom_range(1, 6));
      prio = {$urandom, $urandom};
      ulbt = {$urandom, $urandom};
      mask = (ph % 2 == 1) ? 16'h000F : 16'hFFFF;
      for (int c = 0; c < 1200; c++) begin
        for (int i = 0; i < N; i++)
          if ($urandom_range(0, 5) == 0) req[i] = ~req[i];
        req  = req & mask;
        beat = N'($urandom);
        bend = N'($urandom & $urandom);
        bst  = N'($urandom & $urandom & $urandom);
        tick();
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule